// File: doc/BRIEF.md
# Link delay asymmetry calculator

This block is a sequential fixed-point arithmetic unit for one port of a time-synchronisation system. It takes the master's transmit fixed delay, the slave's receive fixed delay, the sum of all fixed hardware delays (Delta), the measured link delay (mu) and a medium correlation factor (alpha). From these it computes the one-way delay asymmetry of the link with the simplified expression `tx_m + rx_s - (Delta - alpha*mu) / (2 + alpha)`. That expression holds only while Delta is far smaller than mu. The caller must keep to that condition.

A start strobe registers every input. A shift-and-add multiplier forms alpha*mu over one cycle per alpha bit. A restoring divider then produces one quotient bit per cycle. A one-cycle done pulse marks the finished result. The fixed delays have a meaning only once the port is calibrated, so a start with the calibrated input low does not compute. It raises the error flag instead. A correlation factor that makes the divisor zero is also reported as an error.

Top module: `link_asym`

## Requirements
- R1: With calibrated high and a divisor that is not zero, the result equals `tx + rx - q`. Here `q = ((Delta * 2^24) - alpha*mu) / (alpha + 2*2^24)`, computed exactly and truncated toward zero. The error flag is low at that completion.
- R2: All delay inputs and the result are 64-bit two's-complement values with 16 fractional bits. Alpha is a 32-bit two's-complement value with 24 fractional bits. The result wraps modulo 2^64.
- R3: A start accepted with calibrated low makes done_o pulse in the next cycle, with err_o = 1 and result_o = 0.
- R4: A start accepted with calibrated high and alpha = 0xFE000000 (-2.0, zero divisor) makes done_o pulse in the next cycle, with err_o = 1 and result_o = 0.
- R5: done_o is high for exactly one cycle per operation. A computing operation completes within 140 cycles of start, and every computing operation has the same latency.
- R6: A start that arrives while an operation is in progress is ignored. The running operation finishes with the inputs it captured.
- R7: result_o and err_o change only in the cycle in which done_o is high, and they hold until the next completion.
- R8: After reset, done_o, err_o and result_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe; captures all inputs when idle |
| cal_i | input | 1 | Port fixed delays are calibrated |
| tx_m_i | input | 64 | Master transmit fixed delay, ps * 2^16 |
| rx_s_i | input | 64 | Slave receive fixed delay, ps * 2^16 |
| fix_sum_i | input | 64 | Total fixed delay Delta, ps * 2^16 |
| link_i | input | 64 | Measured link delay mu, ps * 2^16 |
| alpha_i | input | 32 | Correlation factor, signed, 24 fractional bits |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Uncalibrated or zero-divisor error |
| result_o | output | 64 | Asymmetry, ps * 2^16, signed |

## Verification
The assertions watch several properties on every cycle:
- done_o stays one cycle wide.
- The result and error flag stay unchanged between completions.
- Captured operands do not move when a start arrives while busy.
- The uncalibrated and zero-divisor starts raise the error flag, with a zero result, in the next cycle.

The arithmetic value itself can only be shown by the bench. It sweeps alpha across sign, magnitude and near-singular values against a range of link delays and computes each expected quotient with wide integer arithmetic. The bench also shows that the latency is the same for every computing operation, and that a start arriving mid-operation leaves the result unchanged.

// File: rtl/asym_pkg.sv
package asym_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARM,
    ST_MUL,
    ST_DIV
  } asym_state_e;
endpackage

// File: rtl/asym_mul.sv
// Sign-magnitude shift-add multiplier, one multiplier bit per clock.
module asym_mul #(
  parameter int AW = 64,
  parameter int BW = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            go_i,
  input  logic [AW-1:0]   a_i,
  input  logic [BW-1:0]   b_i,
  output logic            done_o,
  output logic [AW+BW:0]  p_o
);
  localparam int PW = AW + BW;
  localparam int CW = $clog2(BW + 1);

  logic [AW-1:0] a_mag;
  logic [BW-1:0] b_mag;
  logic [PW-1:0] mcand_q, acc_q;
  logic [BW-1:0] mplier_q;
  logic [CW-1:0] cnt_q;
  logic          neg_q, done_q;

  always_comb begin
    a_mag = a_i[AW-1] ? (~a_i + 1'b1) : a_i;
    b_mag = b_i[BW-1] ? (~b_i + 1'b1) : b_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mcand_q  <= '0;
      acc_q    <= '0;
      mplier_q <= '0;
      cnt_q    <= '0;
      neg_q    <= 1'b0;
      done_q   <= 1'b0;
    end else if (go_i) begin
      mcand_q  <= {{BW{1'b0}}, a_mag};
      mplier_q <= b_mag;
      acc_q    <= '0;
      neg_q    <= a_i[AW-1] ^ b_i[BW-1];
      cnt_q    <= CW'(BW);
      done_q   <= 1'b0;
    end else if (cnt_q != '0) begin
      if (mplier_q[0]) acc_q <= acc_q + mcand_q;
      mcand_q  <= mcand_q << 1;
      mplier_q <= mplier_q >> 1;
      cnt_q    <= cnt_q - 1'b1;
      done_q   <= (cnt_q == CW'(1));
    end else begin
      done_q   <= 1'b0;
    end
  end

  assign done_o = done_q;
  assign p_o    = neg_q ? (~{1'b0, acc_q} + 1'b1) : {1'b0, acc_q};
endmodule

// File: rtl/asym_div.sv
// Restoring divider on magnitudes, one quotient bit per clock; truncates toward zero.
module asym_div #(
  parameter int NW = 97,
  parameter int VW = 33
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic [NW-1:0] num_i,
  input  logic [VW-1:0] den_i,
  output logic          done_o,
  output logic [NW-1:0] q_o
);
  localparam int CW = $clog2(NW + 1);

  logic [NW-1:0] n_mag, quo_q;
  logic [VW-1:0] d_mag, dv_q;
  logic [VW:0]   rem_q, trial;
  logic [CW-1:0] cnt_q;
  logic          neg_q, done_q;

  always_comb begin
    n_mag = num_i[NW-1] ? (~num_i + 1'b1) : num_i;
    d_mag = den_i[VW-1] ? (~den_i + 1'b1) : den_i;
    trial = {rem_q[VW-1:0], quo_q[NW-1]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quo_q  <= '0;
      dv_q   <= '0;
      rem_q  <= '0;
      cnt_q  <= '0;
      neg_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (go_i) begin
      quo_q  <= n_mag;
      dv_q   <= d_mag;
      rem_q  <= '0;
      neg_q  <= num_i[NW-1] ^ den_i[VW-1];
      cnt_q  <= CW'(NW);
      done_q <= 1'b0;
    end else if (cnt_q != '0) begin
      if (trial >= {1'b0, dv_q}) begin
        rem_q <= trial - {1'b0, dv_q};
        quo_q <= {quo_q[NW-2:0], 1'b1};
      end else begin
        rem_q <= trial;
        quo_q <= {quo_q[NW-2:0], 1'b0};
      end
      cnt_q  <= cnt_q - 1'b1;
      done_q <= (cnt_q == CW'(1));
    end else begin
      done_q <= 1'b0;
    end
  end

  assign done_o = done_q;
  assign q_o    = neg_q ? (~quo_q + 1'b1) : quo_q;
endmodule

// File: rtl/link_asym.sv
module link_asym
  import asym_pkg::*;
#(
  parameter int DW = 64,
  parameter int AW = 32,
  parameter int AF = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          cal_i,
  input  logic [DW-1:0] tx_m_i,
  input  logic [DW-1:0] rx_s_i,
  input  logic [DW-1:0] fix_sum_i,
  input  logic [DW-1:0] link_i,
  input  logic [AW-1:0] alpha_i,
  output logic          done_o,
  output logic          err_o,
  output logic [DW-1:0] result_o
);
  localparam int NW = DW + AW + 1;   // signed numerator
  localparam int VW = AW + 1;        // signed divisor
  localparam logic [VW-1:0] TWO = VW'(1) << (AF + 1);

  asym_state_e   state_q;
  logic [DW-1:0] tx_q, rx_q, dl_q, mu_q, res_q;
  logic [AW-1:0] al_q;
  logic [VW-1:0] den_d, den_q;
  logic          done_q, err_q, busy;
  logic          mul_go, mul_done, div_done;
  logic [NW-1:0] prod, num, quo, dl_ext;

  assign den_d  = {alpha_i[AW-1], alpha_i} + TWO;
  assign busy   = (state_q != ST_IDLE);
  assign mul_go = (state_q == ST_ARM);
  assign dl_ext = {{(NW-DW){dl_q[DW-1]}}, dl_q} << AF;
  assign num    = dl_ext - prod;

  asym_mul #(.AW(DW), .BW(AW)) i_mul (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .go_i  (mul_go),
    .a_i   (mu_q),
    .b_i   (al_q),
    .done_o(mul_done),
    .p_o   (prod)
  );

  asym_div #(.NW(NW), .VW(VW)) i_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .go_i  (mul_done),
    .num_i (num),
    .den_i (den_q),
    .done_o(div_done),
    .q_o   (quo)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tx_q    <= '0;
      rx_q    <= '0;
      dl_q    <= '0;
      mu_q    <= '0;
      al_q    <= '0;
      den_q   <= '0;
      res_q   <= '0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          tx_q  <= tx_m_i;
          rx_q  <= rx_s_i;
          dl_q  <= fix_sum_i;
          mu_q  <= link_i;
          al_q  <= alpha_i;
          den_q <= den_d;
          if (!cal_i || den_d == '0) begin
            res_q  <= '0;
            err_q  <= 1'b1;
            done_q <= 1'b1;
          end else begin
            state_q <= ST_ARM;
          end
        end
        ST_ARM: state_q <= ST_MUL;
        ST_MUL: if (mul_done) state_q <= ST_DIV;
        ST_DIV: if (div_done) begin
          res_q   <= tx_q + rx_q - quo[DW-1:0];
          err_q   <= 1'b0;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o   = done_q;
  assign err_o    = err_q;
  assign result_o = res_q;
endmodule

// File: rtl/asym_chk.sv
module asym_chk #(
  parameter int DW = 64,
  parameter int AW = 32,
  parameter int AF = 24
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          cal_i,
  input logic [AW-1:0] alpha_i,
  input logic          busy_i,
  input logic          done_i,
  input logic          err_i,
  input logic [DW-1:0] result_i,
  input logic [DW-1:0] op_q_i
);
  localparam logic [AW-1:0] SING = ~(AW'(1) << (AF + 1)) + 1'b1;

  assert_done_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  assert_hold_result_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |-> ($stable(result_i) && $stable(err_i)));

  assert_busy_ignore_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && start_i) |=> $stable(op_q_i));

  assert_uncal_err_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_i && !cal_i) |=> (done_i && err_i && result_i == '0));

  assert_zero_div_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_i && cal_i && alpha_i == SING) |=> (done_i && err_i && result_i == '0));

  assert_err_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && err_i) |-> (result_i == '0));
endmodule

bind link_asym asym_chk #(.DW(DW), .AW(AW), .AF(AF)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .cal_i   (cal_i),
  .alpha_i (alpha_i),
  .busy_i  (busy),
  .done_i  (done_o),
  .err_i   (err_o),
  .result_i(result_o),
  .op_q_i  (tx_q)
);

// File: tb/test_link_asym.sv
`timescale 1ns/1ps
module test_link_asym;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, cal = 1'b0;
  logic [63:0] tx = '0, rx = '0, dl = '0, mu = '0;
  logic [31:0] al = '0;
  logic        done, err;
  logic [63:0] res;
  int checks = 0, fails = 0, lat0 = -1;

  always #5 clk = ~clk;

  link_asym i_link_asym (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cal_i(cal),
    .tx_m_i(tx), .rx_s_i(rx), .fix_sum_i(dl), .link_i(mu), .alpha_i(al),
    .done_o(done), .err_o(err), .result_o(res)
  );

  function automatic logic [63:0] expect_res(logic [63:0] t, logic [63:0] r, logic [63:0] d,
                                             logic [63:0] m, logic [31:0] a);
    logic signed [127:0] n, dv, q, mm, aa;
    n  = 128'(signed'(d));
    mm = 128'(signed'(m));
    aa = 128'(signed'(a));
    n  = (n <<< 24) - aa * mm;
    dv = aa + (128'sd2 <<< 24);
    q  = n / dv;
    return t + r - q[63:0];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // one operation: start, wait for done, check value, pulse width and hold
  task automatic run_op(input logic [63:0] t, r, d, m, input logic [31:0] a, input logic c);
    int lat = 0;
    logic [63:0] e;
    logic        e_err;
    logic [63:0] held;
    e_err = !c || (a == 32'hFE000000);
    e     = e_err ? 64'd0 : expect_res(t, r, d, m, a);
    tx = t; rx = r; dl = d; mu = m; al = a; cal = c; start = 1'b1;
    do begin
      @(negedge clk);
      start = 1'b0;
      lat++;
    end while (!done && lat < 400);
    if (e_err) begin
      chk(lat == 1, c ? "R4 latency" : "R3 latency", 64'(lat), 64'd1);
      chk(err == 1'b1, c ? "R4 err" : "R3 err", 64'(err), 64'd1);
      chk(res == 64'd0, c ? "R4 result" : "R3 result", res, 64'd0);
    end else begin
      chk(res == e, "R1 R2 result", res, e);
      chk(err == 1'b0, "R1 err", 64'(err), 64'd0);
      chk(lat <= 140, "R5 latency bound", 64'(lat), 64'd140);
      if (lat0 < 0) lat0 = lat;
      chk(lat == lat0, "R5 fixed latency", 64'(lat), 64'(lat0));
    end
    held = res;
    @(negedge clk);
    chk(done == 1'b0, "R5 pulse width", 64'(done), 64'd0);
    tx = ~tx; al = al ^ 32'h5; cal = ~cal;
    @(negedge clk);
    chk(res == held, "R7 hold", res, held);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R5 watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    logic [31:0] alphas [8];
    logic [63:0] mus [6];
    alphas = '{32'h0, 32'h01000000, 32'hFF800000, 32'h00012345,
               32'hFE000001, 32'h7FFFFFFF, 32'h80000000, 32'hFFFFA3C1};
    mus    = '{64'h0, 64'h1, 64'h0000_0100_0000_0000, 64'hFFFF_FFFF_FFFF_0000,
               64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000};
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R8 done", 64'(done), 64'd0);
    chk(err == 1'b0, "R8 err", 64'(err), 64'd0);
    chk(res == 64'd0, "R8 result", res, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2: sweep alpha x mu
    foreach (alphas[i]) begin
      foreach (mus[j]) begin
        run_op({$urandom, $urandom}, {$urandom, $urandom}, {32'h0, $urandom}, mus[j], alphas[i], 1'b1);
      end
    end
    // R1 R2: random operands including wrap
    for (int k = 0; k < 200; k++) begin
      run_op({$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom},
             {$urandom, $urandom}, $urandom, 1'b1);
    end
    // R3: uncalibrated
    run_op(64'h1234, 64'h5678, 64'h10, 64'h99999, 32'h01000000, 1'b0);
    // R4: singular divisor
    run_op(64'h1234, 64'h5678, 64'h10, 64'h99999, 32'hFE000000, 1'b1);
    // R1 after error: flag clears
    run_op(64'h10000, 64'h20000, 64'h3000, 64'h1_0000_0000, 32'h00100000, 1'b1);

    // R6: start while busy is ignored
    begin
      logic [63:0] e;
      int lat = 0;
      e = expect_res(64'hAAAA_0000, 64'h5555_0000, 64'h100_0000, 64'h77_0000_0000, 32'h00200000);
      tx = 64'hAAAA_0000; rx = 64'h5555_0000; dl = 64'h100_0000; mu = 64'h77_0000_0000;
      al = 32'h00200000; cal = 1'b1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (20) @(negedge clk);
      tx = 64'h1; rx = 64'h2; dl = 64'h3; mu = 64'h4; al = 32'hFE000000; cal = 1'b0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!done && lat < 400) begin
        @(negedge clk);
        lat++;
      end
      chk(res == e, "R6 ignored start result", res, e);
      chk(err == 1'b0, "R6 ignored start err", 64'(err), 64'd0);
      @(negedge clk);
      chk(done == 1'b0, "R6 no second done", 64'(done), 64'd0);
    end
    summary();
  end
endmodule